// File: doc/BRIEF.md
# Minterm-Selected Logic Unit

This block is a purely combinational bitwise logic unit for two operands. It can produce any of the sixteen Boolean functions of two inputs. A 4-bit control word is not an opcode into a fixed menu of operations. Each control bit enables one minterm of the operand pair, so the control word is the truth table of the wanted function.

The datapath is a row of identical one-bit slices, one per bit position. All of them share the same control word. Each slice forms the four minterms of its own operand bits and ORs together the minterms whose enable is set. The width is a parameter with a default of 8 and a minimum of 1.

Top module: `minterm_logic_unit`

## Requirements
- R1: For every bit position i, result[i] equals func_sel[k], where the index k = 2*opnd_x[i] + opnd_y[i]. So func_sel[0] enables x'y', func_sel[1] enables x'y, func_sel[2] enables xy', and func_sel[3] enables xy.
- R2: Control code 4'b0000 drives every result bit to 0, whatever the operands.
- R3: Control code 4'b1111 drives every result bit to 1, whatever the operands.
- R4: Control code 4'b1000 gives opnd_x AND opnd_y.
- R5: Control code 4'b1110 gives opnd_x OR opnd_y.
- R6: Control code 4'b0110 gives opnd_x XOR opnd_y.
- R7: Control code 4'b0001 gives opnd_x NOR opnd_y.
- R8: Each result bit depends only on the operand bits at its own position. Changing opnd_x[k] or opnd_y[k] leaves every other result bit unchanged.
- R9: The result is combinational. It follows a change at any input with no clock edge in between, and holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | WIDTH | First operand |
| opnd_y | input | WIDTH | Second operand |
| func_sel | input | 4 | Minterm enables, which form the truth table of the function |
| result | output | WIDTH | Bitwise function of the operands |

## Verification
Every result is due in the same cycle as its stimulus. No register lies between the inputs and result, so zero clock edges separate them. The bench changes the inputs away from the rising clock edge and samples result one time unit later, before any further edge. That sample therefore shows the settled response to exactly that input set. For R8, two input sets that differ in a single operand bit are applied one after the other. The bench compares the two settled results and accepts a difference only at that bit position.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

    // Width of the control word: one enable per minterm of two variables
    localparam int unsigned SEL_W = 4;

    // Named control codes (truth table, MSB = x&y minterm)
    localparam logic [SEL_W-1:0] CODE_ZERO = 4'b0000;
    localparam logic [SEL_W-1:0] CODE_ONE  = 4'b1111;
    localparam logic [SEL_W-1:0] CODE_AND  = 4'b1000;
    localparam logic [SEL_W-1:0] CODE_OR   = 4'b1110;
    localparam logic [SEL_W-1:0] CODE_XOR  = 4'b0110;
    localparam logic [SEL_W-1:0] CODE_NOR  = 4'b0001;

    // Minterms of one operand pair, packed in the same order as the enables
    typedef struct packed {
        logic both;    // x & y
        logic x_only;  // x & ~y
        logic y_only;  // ~x & y
        logic none;    // ~x & ~y
    } minterm_t;

endpackage

// File: rtl/mlu_slice.sv
module mlu_slice
    import mlu_pkg::*;
(
    input  logic             bit_x,
    input  logic             bit_y,
    input  logic [SEL_W-1:0] enables,
    output logic             bit_f
);

    minterm_t mt_d;

    always_comb begin
        mt_d.none   = ~bit_x & ~bit_y;
        mt_d.y_only = ~bit_x &  bit_y;
        mt_d.x_only =  bit_x & ~bit_y;
        mt_d.both   =  bit_x &  bit_y;
    end

    // Sum of the enabled minterms
    always_comb begin
        bit_f = |(enables & mt_d);
    end

endmodule

// File: rtl/minterm_logic_unit.sv
module minterm_logic_unit
    import mlu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  logic [SEL_W-1:0] func_sel,
    output logic [WIDTH-1:0] result
);

    localparam int unsigned LAST = WIDTH - 1;

    logic [LAST:0] slice_out_d;

    generate
        for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
            mlu_slice u_slice (
                .bit_x   (opnd_x[gi]),
                .bit_y   (opnd_y[gi]),
                .enables (func_sel),
                .bit_f   (slice_out_d[gi])
            );
        end
    endgenerate

    assign result = slice_out_d;

endmodule

// File: rtl/minterm_logic_unit_chk.sv
module minterm_logic_unit_chk
    import mlu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_x,
    input logic [WIDTH-1:0] opnd_y,
    input logic [SEL_W-1:0] func_sel,
    input logic [WIDTH-1:0] result
);

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            // R1
            truth_index_chk: assert (result[i] == func_sel[{opnd_x[i], opnd_y[i]}]);
        end
        if (func_sel == CODE_ZERO) begin
            // R2
            all_zero_chk: assert (result == '0);
        end
        if (func_sel == CODE_ONE) begin
            // R3
            all_one_chk: assert (result == '1);
        end
        if (func_sel == CODE_AND) begin
            // R4
            and_code_chk: assert (result == (opnd_x & opnd_y));
        end
        if (func_sel == CODE_OR) begin
            // R5
            or_code_chk: assert (result == (opnd_x | opnd_y));
        end
        if (func_sel == CODE_XOR) begin
            // R6
            xor_code_chk: assert (result == (opnd_x ^ opnd_y));
        end
        if (func_sel == CODE_NOR) begin
            // R7
            nor_code_chk: assert (result == ~(opnd_x | opnd_y));
        end
    end

endmodule

bind minterm_logic_unit minterm_logic_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_x   (opnd_x),
    .opnd_y   (opnd_y),
    .func_sel (func_sel),
    .result   (result)
);

// File: tb/minterm_logic_unit_bench.sv
`timescale 1ns/1ps
module minterm_logic_unit_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x = '0;
    logic [W-1:0] y = '0;
    logic [3:0]   s = '0;
    logic [W-1:0] f;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    minterm_logic_unit #(.WIDTH(W)) u_minterm_logic_unit (
        .opnd_x   (x),
        .opnd_y   (y),
        .func_sel (s),
        .result   (f)
    );

    // Reference from the truth-table reading of the control word
    function automatic logic [W-1:0] ref_f(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[i] = c[2*int'(a[i]) + int'(b[i])];
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (x=%h y=%h s=%b)", req, act, exp, x, y, s);
        end
    endtask

    // Drive just after a falling edge and sample 1 ns later, away from rising edges
    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c);
        @(negedge clk);
        x = a; y = b; s = c;
        #1;
    endtask

    initial begin
        logic [W-1:0] ra, rb, f1;
        int k;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Start-up state with idle inputs (R2)
        apply('0, '0, 4'b0000);
        check("R2 idle", f, '0);

        // Directed codes with corner operands
        apply(8'hF0, 8'hCC, 4'b0000); check("R2", f, 8'h00);
        apply(8'hF0, 8'hCC, 4'b1111); check("R3", f, 8'hFF);
        apply(8'h00, 8'h00, 4'b1111); check("R3 zero operands", f, 8'hFF);
        apply(8'hF0, 8'hCC, 4'b1000); check("R4", f, 8'hC0);
        apply(8'hF0, 8'hCC, 4'b1110); check("R5", f, 8'hFC);
        apply(8'hF0, 8'hCC, 4'b0110); check("R6", f, 8'h3C);
        apply(8'hF0, 8'hCC, 4'b0001); check("R7", f, 8'h03);
        apply(8'hFF, 8'hFF, 4'b0110); check("R6 equal operands", f, 8'h00);
        apply(8'h00, 8'h00, 4'b0001); check("R7 zero operands", f, 8'hFF);
        // Single minterm enables pick out one quadrant each (R1)
        apply(8'hF0, 8'hCC, 4'b0010); check("R1 y-only", f, 8'h0C);
        apply(8'hF0, 8'hCC, 4'b0100); check("R1 x-only", f, 8'h30);

        // Random operands under every control code (R1..R7)
        for (int c = 0; c < 16; c++) begin
            for (int n = 0; n < 24; n++) begin
                ra = W'($urandom); rb = W'($urandom);
                apply(ra, rb, 4'(c));
                check("R1", f, ref_f(ra, rb, 4'(c)));
                if (c == 8)  check("R4 random", f, ra & rb);
                if (c == 14) check("R5 random", f, ra | rb);
                if (c == 6)  check("R6 random", f, ra ^ rb);
                if (c == 1)  check("R7 random", f, ~(ra | rb));
            end
        end

        // Bit independence: flip one operand bit, only that output bit may move (R8)
        for (int n = 0; n < 40; n++) begin
            ra = W'($urandom); rb = W'($urandom);
            k = int'($urandom % W);
            apply(ra, rb, 4'($urandom));
            f1 = f;
            if (n % 2 == 0) apply(ra ^ (W'(1) << k), rb, s);
            else            apply(ra, rb ^ (W'(1) << k), s);
            check("R8", (f ^ f1) & ~(W'(1) << k), '0);
        end

        // Output follows input changes with no clock edge in between (R9)
        @(posedge clk);
        #2;
        x = 8'hAA; y = 8'h55; s = 4'b1110;
        #1;
        check("R9 same cycle", f, 8'hFF);
        s = 4'b1000;
        #1;
        check("R9 no held state", f, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule